// File: doc/BRIEF.md
# Paired-Bit Message Object Control Register

This block is the 16-bit control word of one message object in a CAN controller. It holds eight flags, and each flag takes two bits of the word. The host updates any subset of flags in one write and never has to read the word back first. In each two-bit field, code 10 sets the flag, code 01 clears it, and codes 11 or 00 leave it alone. A read returns 10 in a field whose flag is true and 01 in a field whose flag is false.

Three hardware events also act on the flags. A transmission that completed and was acknowledged clears the transmit request and the remote-pending flag, provided new-data is still clear, and it raises a one-cycle transmit-OK pulse. A stored data frame sets new-data. A matching remote frame sets remote-pending. The flag vector and a send request feed the transmit scheduler and the interrupt logic. The send request is suppressed while the CPU-update flag is set.

Top module: `flag_pair_reg`

## Requirements
- R1: After reset every flag is false, the read word is 0x5555, and sendReq and txOk are 0.
- R2: A write with field code 10 sets that flag and a write with code 01 clears it, one cycle after the write.
- R3: Field codes 11 and 00 leave that flag unchanged.
- R4: Flag i occupies read bits [2i+1:2i] and reads 10 when true and 01 when false. Flag indices 7..0 are: remote-pending, transmit-request, CPU-update, new-data, message-valid, transmit-interrupt-enable, receive-interrupt-enable, interrupt-pending. The flags output carries the flag with index i on bit i.
- R5: Writing 0x5555 clears all eight flags, message-valid included.
- R6: Writing 0xE7FF sets transmit-request, clears CPU-update and changes nothing else.
- R7: A txDone pulse while new-data is 0 clears transmit-request and remote-pending on the next edge, and txOk is high for exactly that one cycle.
- R8: A txDone pulse while new-data is 1 changes no flag and gives no txOk.
- R9: A frameStored pulse sets new-data, which shows as read bit 9.
- R10: A remoteRx pulse sets remote-pending.
- R11: sendReq is high exactly when transmit-request and message-valid are set and CPU-update is clear.
- R12: When a hardware event and a host write hit the same flag in the same cycle, the hardware event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 16 | Host write word, two code bits per flag |
| txDone | input | 1 | Successful, acknowledged transmission (pulse) |
| frameStored | input | 1 | Data frame stored into the object (pulse) |
| remoteRx | input | 1 | Matching remote frame received (pulse) |
| rdData | output | 16 | Host read word, 10/01 per flag |
| flags | output | 8 | Flag values, index as in R4 |
| sendReq | output | 1 | Object is ready to transmit |
| txOk | output | 1 | Transmit-OK status pulse |

## Verification
The bench sweeps every one of the 256 starting flag patterns and applies each of the four codes to each flag while every other field holds 11. This catches a decoder that swaps 10 and 01, that treats 00 as a clear, or whose write disturbs neighbouring fields. The transmit-complete case runs with new-data both clear and set, so a design that ignores the new-data guard, or that keeps txOk high, shows up. Same-cycle collisions between host writes and frame or transmit events expose a design in which the host write overrides the hardware.

// File: rtl/flag_pair_pkg.sv
package flag_pair_pkg;
  localparam int FLAG_COUNT = 8;
  localparam int WORD_W     = 2 * FLAG_COUNT;

  // flag indices; the host software decodes these positions
  localparam int IDX_INT_PEND   = 0;
  localparam int IDX_RX_IE      = 1;
  localparam int IDX_TX_IE      = 2;
  localparam int IDX_MSG_VALID  = 3;
  localparam int IDX_NEW_DATA   = 4;
  localparam int IDX_CPU_UPD    = 5;
  localparam int IDX_TX_REQ     = 6;
  localparam int IDX_REMOTE_PND = 7;

  localparam logic [1:0] CODE_SET  = 2'b10;
  localparam logic [1:0] CODE_CLR  = 2'b01;

  typedef struct packed {
    logic [FLAG_COUNT-1:0] setMask;
    logic [FLAG_COUNT-1:0] clrMask;
    logic                  txOkPulse;
  } flag_strobes_t;
endpackage

// File: rtl/flag_pair_ctrl.sv
module flag_pair_ctrl
  import flag_pair_pkg::*;
(
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              txDone,
  input  logic              frameStored,
  input  logic              remoteRx,
  input  logic              newDataNow,
  output flag_strobes_t     strb
);
  logic [FLAG_COUNT-1:0] hostSet, hostClr, hwSet, hwClr;
  logic                  txClears;

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_COUNT; gi++) begin : g_decode
      assign hostSet[gi] = wrEn && (wrData[2*gi+1 -: 2] == CODE_SET);
      assign hostClr[gi] = wrEn && (wrData[2*gi+1 -: 2] == CODE_CLR);
    end
  endgenerate

  assign txClears = txDone && !newDataNow;

  always_comb begin
    hwSet = '0;
    hwClr = '0;
    hwSet[IDX_NEW_DATA]   = frameStored;
    hwSet[IDX_REMOTE_PND] = remoteRx;
    hwClr[IDX_TX_REQ]     = txClears;
    hwClr[IDX_REMOTE_PND] = txClears;
  end

  // priority: hardware set, then hardware clear, then host
  always_comb begin
    strb.setMask   = hwSet | (hostSet & ~hwClr);
    strb.clrMask   = ~hwSet & (hwClr | (hostClr & ~hwSet));
    strb.txOkPulse = txClears;
  end
endmodule

// File: rtl/flag_pair_dp.sv
module flag_pair_dp
  import flag_pair_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  flag_strobes_t         strb,
  output logic [FLAG_COUNT-1:0] flagQ,
  output logic                  txOkQ,
  output logic [WORD_W-1:0]     rdWord
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      txOkQ <= 1'b0;
    end else begin
      flagQ <= (flagQ & ~strb.clrMask) | strb.setMask;
      txOkQ <= strb.txOkPulse;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_COUNT; gi++) begin : g_encode
      assign rdWord[2*gi+1 -: 2] = flagQ[gi] ? CODE_SET : CODE_CLR;
    end
  endgenerate

  // the control never asks for both actions on one flag
  assert_set_clr_disjoint_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask & strb.clrMask) == '0);

  // an active set strobe is seen in the register next cycle
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask != '0) |=> ((flagQ & $past(strb.setMask)) == $past(strb.setMask)));
endmodule

// File: rtl/flag_pair_reg.sv
module flag_pair_reg
  import flag_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        txDone,
  input  logic        frameStored,
  input  logic        remoteRx,
  output logic [15:0] rdData,
  output logic [7:0]  flags,
  output logic        sendReq,
  output logic        txOk
);
  flag_strobes_t strb;

  flag_pair_ctrl u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .txDone(txDone), .frameStored(frameStored),
    .remoteRx(remoteRx), .newDataNow(flags[IDX_NEW_DATA]), .strb(strb)
  );

  flag_pair_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flagQ(flags), .txOkQ(txOk), .rdWord(rdData)
  );

  assign sendReq = flags[IDX_TX_REQ] && flags[IDX_MSG_VALID] && !flags[IDX_CPU_UPD];

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == 16'h5555 && !frameStored && !remoteRx) |=> (flags == '0));

  assert_tx_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !flags[IDX_NEW_DATA] && !remoteRx) |=>
      (!flags[IDX_TX_REQ] && !flags[IDX_REMOTE_PND] && txOk));

  assert_tx_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && flags[IDX_NEW_DATA]) |=> !txOk);

  assert_frame_stored_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStored |=> (flags[IDX_NEW_DATA] && rdData[9]));

  assert_remote_rx_R10: assert property (@(posedge clk) disable iff (!rstN)
    remoteRx |=> flags[IDX_REMOTE_PND]);

  assert_keep_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == 16'hFFFF && !txDone && !frameStored && !remoteRx) |=> $stable(flags));
endmodule

// File: tb/flag_pair_reg_bench.sv
module flag_pair_reg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        txDone = 1'b0, frameStored = 1'b0, remoteRx = 1'b0;
  logic [15:0] rdData;
  logic [7:0]  flags;
  logic        sendReq, txOk;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flag_pair_reg u_flag_pair_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .txDone(txDone),
    .frameStored(frameStored), .remoteRx(remoteRx), .rdData(rdData),
    .flags(flags), .sendReq(sendReq), .txOk(txOk)
  );

  function automatic logic [15:0] encodeWord(input logic [7:0] f);
    logic [15:0] w;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = f[i] ? 2'b10 : 2'b01;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic checkState(input string req, input logic [7:0] exp);
    check(req, {16'h0, rdData}, {16'h0, encodeWord(exp)});
    check(req, {24'h0, flags}, {24'h0, exp});
    check({req, " R11"}, {31'h0, sendReq}, {31'h0, exp[6] & exp[3] & ~exp[5]});
  endtask

  task automatic drive(input logic we, input logic [15:0] d, input logic td,
                       input logic fs, input logic rr);
    @(negedge clk);
    wrEn = we; wrData = d; txDone = td; frameStored = fs; remoteRx = rr;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; txDone = 1'b0; frameStored = 1'b0; remoteRx = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkState("R1", 8'h00);
    check("R1 txOk", {31'h0, txOk}, 32'h0);

    // R2 R3 R4: every base pattern, every flag, every code
    for (int base = 0; base < 256; base++) begin
      drive(1'b1, encodeWord(base[7:0]), 1'b0, 1'b0, 1'b0);
      checkState("R4", base[7:0]);
      for (int idx = 0; idx < 8; idx++) begin
        for (int code = 0; code < 4; code++) begin
          logic [15:0] w;
          w = 16'hFFFF;
          w[2*idx +: 2] = code[1:0];
          exp = base[7:0];
          if (code == 2) exp[idx] = 1'b1;
          if (code == 1) exp[idx] = 1'b0;
          drive(1'b1, w, 1'b0, 1'b0, 1'b0);
          checkState((code == 1 || code == 2) ? "R2" : "R3", exp);
          drive(1'b1, encodeWord(base[7:0]), 1'b0, 1'b0, 1'b0);
        end
      end
    end

    // R5 clear everything
    drive(1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0);
    checkState("R2", 8'hFF);
    drive(1'b1, 16'h5555, 1'b0, 1'b0, 1'b0);
    checkState("R5", 8'h00);

    // R6 send word on a mixed pattern
    drive(1'b1, encodeWord(8'b0010_1101), 1'b0, 1'b0, 1'b0);
    drive(1'b1, 16'hE7FF, 1'b0, 1'b0, 1'b0);
    checkState("R6", 8'b0100_1101);

    // R7 transmit complete with new-data clear
    drive(1'b1, encodeWord(8'b1100_1000), 1'b0, 1'b0, 1'b0);
    check("R11 ready", {31'h0, sendReq}, 32'h1);
    drive(1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    checkState("R7", 8'b0000_1000);
    check("R7 txOk", {31'h0, txOk}, 32'h1);
    @(negedge clk);
    check("R7 txOk one cycle", {31'h0, txOk}, 32'h0);

    // R8 transmit complete with new-data set
    drive(1'b1, encodeWord(8'b1101_1000), 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    checkState("R8", 8'b1101_1000);
    check("R8 txOk", {31'h0, txOk}, 32'h0);

    // R9 frame stored
    drive(1'b1, 16'h5555, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0, 1'b0, 1'b1, 1'b0);
    checkState("R9", 8'b0001_0000);
    check("R9 bit9", {31'h0, rdData[9]}, 32'h1);

    // R10 remote frame
    drive(1'b1, 16'h5555, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    checkState("R10", 8'b1000_0000);

    // R12 collisions
    drive(1'b1, 16'h5555, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 16'hFDFF, 1'b0, 1'b1, 1'b0);
    checkState("R12 newData", 8'b0001_0000);
    drive(1'b1, 16'h5555, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 16'hEFFF, 1'b1, 1'b0, 1'b0);
    checkState("R12 txReq", 8'b0000_0000);
    check("R12 txOk", {31'h0, txOk}, 32'h1);
    drive(1'b1, 16'h7FFF, 1'b0, 1'b0, 1'b1);
    checkState("R12 remote", 8'b1000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule